// File: doc/BRIEF.md
# Latency-Modelled Byte-Wide Block Memory

This block stands in for off-chip memory behind a cache. The cache places a command on a two-bit input each cycle: idle, read a block or write a block. Whenever the model is ready, it takes a read or write command together with a block index. It then holds its ready flag low and waits a fixed number of cycles, set by the `LATENCY` parameter. After that wait it moves a whole 32-byte block over an 8-bit bus, one byte per clock, in ascending byte order. On a read, each byte comes out with a valid strobe. On a write, the byte on the write-data bus is stored in each transfer cycle. When the last byte has moved, ready returns high, so a stalled cache can carry on.

The sequencer has four states:

- IDLE: waits for a command.
- WAIT: counts the latency cycles.
- XFER: steps a byte index from 0 to 31.
- DONE: a single completion cycle with ready high.

The transitions are:

- Accept: IDLE or DONE to WAIT. If `LATENCY` is 0, the accept goes straight to XFER instead.
- Wait-expired: WAIT to XFER, after `LATENCY` cycles.
- Last-byte: XFER to DONE, after byte 31.
- Return: DONE to IDLE, when no command is present.

The storage depth is a parameter (default 64 bytes, two blocks). On reset every storage byte is loaded with a known pattern.

Top module: `bytewide_dram_model`

## Requirements
- R1: After reset, ready_o is 1 and rvalid_o is 0, and the byte at address a holds (a*37+11) mod 256.
- R2: A command of 2'b01 (read) or 2'b10 (write) seen while ready_o is 1 is accepted. ready_o then reads 0 from the next cycle for exactly LATENCY+32 cycles, then 1.
- R3: After acceptance the model waits LATENCY cycles. rvalid_o is high in exactly cycles LATENCY+1 to LATENCY+32 after the accepting edge.
- R4: During a read, rdata_o carries the byte at address blk*32+k in the k-th transfer cycle, k = 0..31 ascending.
- R5: rvalid_o is never high while ready_o is 1, during the wait, or during a write.
- R6: During a write, wdata_i in the k-th transfer cycle is stored at address blk*32+k. Other blocks keep their contents.
- R7: Commands presented while ready_o is 0 are ignored. They change neither the timing nor the storage.
- R8: The block index and the operation are captured at acceptance. Later changes of blk_addr_i have no effect on the running transfer.
- R9: A command of 2'b00 or 2'b11 is not accepted, and ready_o stays 1.
- R10: A command presented in the completion cycle, the first cycle ready_o is 1 again, is accepted at once.
- R11: With LATENCY = 0, the first byte moves in the cycle after acceptance and the busy time is 32 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 2 | Command: 00 idle, 01 read, 10 write, 11 reserved (idle) |
| blk_addr_i | input | BLK_W | Block index, captured at acceptance |
| wdata_i | input | 8 | Write byte, stored in each write transfer cycle |
| ready_o | output | 1 | High when a command can be accepted |
| rdata_o | output | 8 | Read byte, 0 when rvalid_o is low |
| rvalid_o | output | 1 | Strobe marking each read byte |

## Verification
The hardest situations to reach from the ports are the ones where the inputs change while the model is busy:

- A conflicting command arrives mid-transfer.
- The block index moves after acceptance.
- A new command is presented in the single completion cycle.

To reach them, the driver keeps issuing the opposite operation to the other block throughout every busy period of some transfers, and then reads both blocks back. It also chains a read directly onto a write in the completion cycle. A second instance with zero latency is run on its own command line, so that the wait-free path is timed against the same expected storage pattern.

// File: rtl/bdm_pkg.sv
package bdm_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_RSVD  = 2'b11
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XFER,
        ST_DONE
    } state_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/bdm_cmd_dec.sv
module bdm_cmd_dec
    import bdm_pkg::*;
(
    input  logic [1:0] cmd_i,
    input  logic       ready_i,
    output logic       start_o,
    output logic       wr_o
);

    always_comb begin
        start_o = 1'b0;
        wr_o    = 1'b0;
        unique case (cmd_t'(cmd_i))
            CMD_READ: begin
                start_o = ready_i;
                wr_o    = 1'b0;
            end
            CMD_WRITE: begin
                start_o = ready_i;
                wr_o    = 1'b1;
            end
            CMD_IDLE, CMD_RSVD: begin
                start_o = 1'b0;
                wr_o    = 1'b0;
            end
            default: begin
                start_o = 1'b0;
                wr_o    = 1'b0;
            end
        endcase
    end

    always_comb begin
        assert_no_start_busy_R7: assert (!(start_o && !ready_i));
    end

endmodule

// File: rtl/bdm_seq.sv
module bdm_seq
    import bdm_pkg::*;
#(
    parameter int LATENCY     = 3,
    parameter int BLOCK_BYTES = 32,
    parameter int BLK_W       = 1,
    localparam int IDX_W      = $clog2(BLOCK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             wr_i,
    input  logic [BLK_W-1:0] blk_i,
    output logic             ready_o,
    output logic             xfer_o,
    output logic             wr_q_o,
    output logic [BLK_W-1:0] blk_q_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam bit            HAS_WAIT = (LATENCY > 0);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_BYTES - 1);

    state_t           st_q, st_d;
    logic [IDX_W-1:0] idx_q;
    logic [BLK_W-1:0] blk_q;
    logic             wr_q;
    logic             lat_done;

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) st_d = HAS_WAIT ? ST_WAIT : ST_XFER;
            end
            ST_WAIT: begin
                if (lat_done) st_d = ST_XFER;
            end
            ST_XFER: begin
                if (idx_q == LAST_IDX) st_d = ST_DONE;
            end
            ST_DONE: begin
                if (start_i) st_d = HAS_WAIT ? ST_WAIT : ST_XFER;
                else         st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // operation capture and byte index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            blk_q <= '0;
            wr_q  <= 1'b0;
        end else if (start_i) begin
            idx_q <= '0;
            blk_q <= blk_i;
            wr_q  <= wr_i;
        end else if (st_q == ST_XFER) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // latency counter, present only when a wait is modelled
    generate
        if (HAS_WAIT) begin : g_wait
            localparam int LAT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
            logic [LAT_W-1:0] lat_q;
            always_ff @(posedge clk) begin
                if (!rst_n)               lat_q <= '0;
                else if (st_q == ST_WAIT) lat_q <= lat_q + 1'b1;
                else                      lat_q <= '0;
            end
            assign lat_done = (lat_q == LAT_W'(LATENCY - 1));

            assert_wait_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q == ST_WAIT) |-> (int'(lat_q) < LATENCY));
        end else begin : g_nowait
            assign lat_done = 1'b1;
        end
    endgenerate

    // outputs
    always_comb begin
        ready_o = 1'b0;
        xfer_o  = 1'b0;
        unique case (st_q)
            ST_IDLE: ready_o = 1'b1;
            ST_WAIT: ready_o = 1'b0;
            ST_XFER: xfer_o  = 1'b1;
            ST_DONE: ready_o = 1'b1;
            default: ready_o = 1'b0;
        endcase
    end

    assign wr_q_o  = wr_q;
    assign blk_q_o = blk_q;
    assign idx_o   = idx_q;

    assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !ready_o);

    assert_blk_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !start_i) |=> $stable(blk_q) && $stable(wr_q));

    assert_idx_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_XFER && idx_q != LAST_IDX) |=>
            (st_q == ST_XFER && idx_q == $past(idx_q) + 1'b1));

    assert_last_finishes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_XFER && idx_q == LAST_IDX) |=> ready_o);

endmodule

// File: rtl/bdm_store.sv
module bdm_store
    import bdm_pkg::*;
#(
    parameter int MEM_BYTES = 64,
    localparam int ADDR_W   = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o
);

    logic [BYTE_W-1:0] mem_q [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                mem_q[i] <= BYTE_W'(i * 37 + 11);
            end
        end else if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/bytewide_dram_model.sv
module bytewide_dram_model
    import bdm_pkg::*;
#(
    parameter int LATENCY     = 3,
    parameter int BLOCK_BYTES = 32,
    parameter int MEM_BYTES   = 64,
    localparam int NUM_BLK    = MEM_BYTES / BLOCK_BYTES,
    localparam int BLK_W      = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_i,
    input  logic [BLK_W-1:0]  blk_addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic              ready_o,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              rvalid_o
);

    localparam int IDX_W  = $clog2(BLOCK_BYTES);
    localparam int ADDR_W = $clog2(MEM_BYTES);

    logic              start, wr_cmd, ready, xfer, wr_q;
    logic [BLK_W-1:0]  blk_q;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] mem_rd;

    bdm_cmd_dec u_dec (
        .cmd_i   (cmd_i),
        .ready_i (ready),
        .start_o (start),
        .wr_o    (wr_cmd)
    );

    bdm_seq #(
        .LATENCY     (LATENCY),
        .BLOCK_BYTES (BLOCK_BYTES),
        .BLK_W       (BLK_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .wr_i    (wr_cmd),
        .blk_i   (blk_addr_i),
        .ready_o (ready),
        .xfer_o  (xfer),
        .wr_q_o  (wr_q),
        .blk_q_o (blk_q),
        .idx_o   (idx)
    );

    generate
        if (NUM_BLK > 1) begin : g_multi
            assign addr = {blk_q, idx};
        end else begin : g_single
            logic unused_blk;
            assign unused_blk = ^blk_q;
            assign addr = ADDR_W'(idx);
        end
    endgenerate

    bdm_store #(
        .MEM_BYTES (MEM_BYTES)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (xfer && wr_q),
        .addr_i  (addr),
        .wdata_i (wdata_i),
        .rdata_o (mem_rd)
    );

    assign ready_o  = ready;
    assign rvalid_o = xfer && !wr_q;
    assign rdata_o  = rvalid_o ? mem_rd : '0;

    assert_rvalid_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> !ready_o);

    assert_write_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && wr_q) |-> !ready_o && !rvalid_o);

endmodule

// File: tb/tb_bytewide_dram_model.sv
module tb_bytewide_dram_model;

    localparam int LAT = 3;
    localparam int BLK = 32;
    localparam int MEM = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic [1:0] cmd_z = 2'b00;
    logic       blk_addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       rdy, rv, rdy_z, rv_z;
    logic [7:0] rd, rd_z;

    int total = 0;
    int bad = 0;
    logic [7:0] model [MEM];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    bytewide_dram_model #(.LATENCY(LAT), .BLOCK_BYTES(BLK), .MEM_BYTES(MEM)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .blk_addr_i(blk_addr),
        .wdata_i(wdata), .ready_o(rdy), .rdata_o(rd), .rvalid_o(rv));

    bytewide_dram_model #(.LATENCY(0), .BLOCK_BYTES(BLK), .MEM_BYTES(MEM)) dut_z (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_z), .blk_addr_i(blk_addr),
        .wdata_i(wdata), .ready_o(rdy_z), .rdata_o(rd_z), .rvalid_o(rv_z));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] wbyte(input int seed, input int k);
        return 8'(seed * 13 + k * 5 + 1);
    endfunction

    // monitor: pops expected read bytes as the design emits them
    always @(negedge clk) begin
        if (rst_n && rv) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 rvalid with nothing expected", rd, -1);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rd == e, t, rd, e);
            end
        end
    end

    // driver: one operation, optionally with conflicting traffic while busy
    task automatic run_op(input logic [1:0] op, input logic b, input int seed,
                          input bit noise, input bit imm, output int busy);
        int win_err;
        if (!imm) @(negedge clk);
        if (op == 2'b01) begin
            for (int k = 0; k < BLK; k++) begin
                exp_q.push_back(model[b * BLK + k]);
                tag_q.push_back("R4 read byte");
            end
        end
        cmd = op;
        blk_addr = b;
        @(negedge clk);
        cmd = noise ? ((op == 2'b01) ? 2'b10 : 2'b01) : 2'b00;
        if (noise) blk_addr = ~b;
        busy = 0;
        win_err = 0;
        for (int n = 1; n <= LAT + 40; n++) begin
            if (rdy) break;
            busy++;
            if (rv != ((op == 2'b01) && n > LAT && n <= LAT + BLK)) win_err++;
            if (op == 2'b10 && n > LAT && n <= LAT + BLK) begin
                wdata = wbyte(seed, n - LAT - 1);
                model[b * BLK + n - LAT - 1] = wdata;
            end
            @(negedge clk);
        end
        cmd = 2'b00;
        blk_addr = 1'b0;
        if (op == 2'b01) chk(win_err == 0, "R3 rvalid window", win_err, 0);
        else             chk(win_err == 0, "R5 no rvalid during write", win_err, 0);
    endtask

    initial begin
        #(20 * 100000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int busy;
        int errs;
        for (int a = 0; a < MEM; a++) model[a] = 8'(a * 37 + 11);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdy == 1'b1, "R1 ready after reset", rdy, 1);
        chk(rv == 1'b0, "R1 rvalid after reset", rv, 0);
        chk(rdy_z == 1'b1, "R1 ready after reset (zero latency)", rdy_z, 1);

        // initial contents of block 0
        run_op(2'b01, 1'b0, 0, 1'b0, 1'b0, busy);
        chk(busy == LAT + BLK, "R2 read busy time", busy, LAT + BLK);

        // write block 1, then read both blocks back
        run_op(2'b10, 1'b1, 1, 1'b0, 1'b0, busy);
        chk(busy == LAT + BLK, "R2 write busy time", busy, LAT + BLK);
        run_op(2'b01, 1'b1, 0, 1'b0, 1'b0, busy);
        chk(busy == LAT + BLK, "R6 readback busy", busy, LAT + BLK);
        run_op(2'b01, 1'b0, 0, 1'b0, 1'b0, busy);

        // read block 0 while writes to block 1 are offered
        run_op(2'b01, 1'b0, 0, 1'b1, 1'b0, busy);
        chk(busy == LAT + BLK, "R7 busy time with ignored commands", busy, LAT + BLK);
        run_op(2'b01, 1'b1, 0, 1'b0, 1'b0, busy);

        // write block 0 while reads of block 1 are offered and the index moves
        run_op(2'b10, 1'b0, 2, 1'b1, 1'b0, busy);
        chk(busy == LAT + BLK, "R8 write busy with index change", busy, LAT + BLK);
        run_op(2'b01, 1'b0, 0, 1'b0, 1'b0, busy);
        run_op(2'b01, 1'b1, 0, 1'b0, 1'b0, busy);

        // back-to-back through the completion cycle
        run_op(2'b10, 1'b1, 3, 1'b0, 1'b0, busy);
        chk(rdy == 1'b1, "R10 completion cycle ready", rdy, 1);
        run_op(2'b01, 1'b1, 0, 1'b0, 1'b1, busy);
        chk(busy == LAT + BLK, "R10 command in completion cycle accepted", busy, LAT + BLK);

        // idle and reserved codes
        @(negedge clk);
        cmd = 2'b11;
        @(negedge clk);
        chk(rdy == 1'b1, "R9 reserved code not accepted", rdy, 1);
        cmd = 2'b00;
        @(negedge clk);
        chk(rdy == 1'b1, "R9 idle code keeps ready", rdy, 1);

        // zero-latency instance reading block 1 (reset pattern)
        blk_addr = 1'b1;
        cmd_z = 2'b01;
        @(negedge clk);
        cmd_z = 2'b00;
        busy = 0;
        errs = 0;
        for (int n = 1; n <= 40; n++) begin
            if (rdy_z) break;
            busy++;
            if (!rv_z || rd_z != 8'((BLK + n - 1) * 37 + 11)) errs++;
            @(negedge clk);
        end
        chk(busy == BLK, "R11 zero-latency busy time", busy, BLK);
        chk(errs == 0, "R11 zero-latency data from first cycle", errs, 0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all expected bytes seen", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule